// File: doc/BRIEF.md
# Triggered Capture Controller

This block governs how a 34-channel logic sampler fills its capture memory. A sample strobe is derived from the core clock by a programmable terminal-count divider, or taken on every core clock when the bypass input is set. Each sample is tested against a trigger condition built from three 34-bit fields: a care mask, an edge-select mask and a match-value field. Until that condition holds, no sample reaches memory. The sample that satisfies it is written first, and writing continues at consecutive addresses until a programmable fill threshold is reached or a stop command arrives.

The host arms a run with a start pulse. It then polls the status flags (triggered, memory available, capturing), the fill level and an elapsed-time counter. That counter advances once per fixed number of core clocks, whatever the divider setting. Its unit is therefore only exact at the nominal base rate and becomes shorter when the divider is bypassed at a faster core clock. The host normally loads the fill threshold as the memory depth minus 16, which keeps a margin for latency downstream of the write port. Written words keep only the enabled channels; disabled channels are stored as zero.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset, capturing and triggered read 0, memory-available reads 1, fill level reads 4, duration reads 0 and no write strobe is issued.
- R2: A start pulse without stop sets capturing and memory-available to 1, clears triggered, returns the fill level to 4, clears duration and restarts the divider and edge history; when start and stop are high together, stop wins and capturing reads 0.
- R3: With bypass low and terminal count N, a sample is taken on every (N+1)-th edge while capturing, the first one on the (N+1)-th edge after the start edge.
- R4: With bypass high, every clock edge while capturing takes a sample and the terminal count has no effect.
- R5: A sample satisfies the trigger when every channel whose care bit is 1 meets its condition; a channel with care 1 and edge-select 0 meets it when its level equals its match bit; with an all-zero care mask the first sample triggers.
- R6: A channel with care 1 and edge-select 1 meets its condition only when it differs from the previous sample and equals its match bit (1 = rising, 0 = falling); the first sample after start has no previous sample and never meets an edge condition.
- R7: No word is written before the trigger; the triggering sample is written first at address 4 and later samples at consecutive addresses; the write strobe, address and data appear one edge after the sampling edge, and the data is the sample ANDed with the channel enable mask.
- R8: The write to address fill_limit-1 is the last one: on that edge capturing and memory-available drop to 0 and the fill level becomes fill_limit.
- R9: After an edge with stop high, capturing reads 0, no further write strobe is issued and the fill level stays frozen; triggered keeps its value.
- R10: Duration increments once every TICKS_PER_UNIT clock edges while capturing, counting from the start edge, independent of bypass and divider settings, and holds its value while not capturing.
- R11: The fill level always equals the next write address, that is, one more than the last address written in the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a new capture run (pulse) |
| stop | input | 1 | Ends the current run (pulse, wins over start) |
| bypass | input | 1 | Sample on every clock, ignoring the divider |
| div_count | input | DIV_W | Divider terminal count (sample period minus one) |
| chan_en | input | 34 | Channel enable mask applied to written data |
| trig_value | input | 34 | Match value per channel |
| trig_edge | input | 34 | Per-channel edge select (1 = edge, 0 = level) |
| trig_care | input | 34 | Per-channel care mask |
| fill_limit | input | ADDR_W | Memory-full threshold |
| din | input | 34 | Channel inputs |
| mem_we | output | 1 | Capture memory write strobe |
| mem_addr | output | ADDR_W | Capture memory write address |
| mem_data | output | 34 | Capture memory write data |
| fill_level | output | ADDR_W | Next write address |
| stat_triggered | output | 1 | Trigger has fired in this run |
| stat_mem_avail | output | 1 | Memory has not reached the threshold |
| stat_capturing | output | 1 | A run is active |
| duration | output | DUR_W | Elapsed time units in this run |

## Verification
The bench goes after the first sample after start, where a design that kept edge history across runs or compared against a reset value of zero would fire an edge trigger with no real transition. It checks the exact edge of the first divided sample, which an off-by-one terminal count would shift, and the last write before the threshold, where an early or late compare would leave the fill level one off or write into the reserved margin. It also checks that duration counts the same in bypass and divided modes and freezes after stop, and that stop beats a simultaneous start. A design that let start win there would silently re-arm.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int CAP_CH     = 34;
    localparam int FIRST_ADDR = 4;

    typedef logic [CAP_CH-1:0] chan_t;

    typedef struct packed {
        chan_t value;
        chan_t edge_sel;
        chan_t care;
    } trig_cfg_t;

    typedef struct packed {
        logic triggered;
        logic mem_avail;
        logic capturing;
    } cap_flags_t;

    // Every cared channel must meet its level or edge condition.
    function automatic logic trig_hit(trig_cfg_t cfg, chan_t cur, chan_t prev, logic prev_ok);
        chan_t lvl_ok;
        chan_t changed;
        chan_t ch_ok;
        lvl_ok  = ~(cur ^ cfg.value);
        changed = (cur ^ prev) & {CAP_CH{prev_ok}};
        ch_ok   = ~cfg.care | (lvl_ok & (~cfg.edge_sel | changed));
        return &ch_ok;
    endfunction

endpackage

// File: rtl/cap_rate_gen.sv
module cap_rate_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             bypass,
    input  logic [DIV_W-1:0] div_count,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run & (bypass | (cnt == div_count));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            if (tick) cnt <= '0;
            else      cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cap_trig_unit.sv
module cap_trig_unit
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      tick,
    input  trig_cfg_t cfg,
    input  chan_t     din,
    output logic      hit
);
    chan_t prev;
    logic  prev_ok;

    assign hit = trig_hit(cfg, din, prev, prev_ok);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else if (tick) begin
            prev    <= din;
            prev_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/cap_dur_timer.sv
module cap_dur_timer #(
    parameter int TICKS_PER_UNIT = 100000,
    parameter int DUR_W          = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    output logic [DUR_W-1:0] duration
);
    localparam int TW = $clog2(TICKS_PER_UNIT + 1);
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_UNIT - 1);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tcnt     <= '0;
            duration <= '0;
        end else if (run) begin
            if (tcnt == LAST) begin
                tcnt     <= '0;
                duration <= duration + 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import cap_pkg::*;
#(
    parameter int MEM_DEPTH      = 4096,
    parameter int DIV_W          = 16,
    parameter int TICKS_PER_UNIT = 100000,
    parameter int DUR_W          = 32,
    localparam int ADDR_W        = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              bypass,
    input  logic [DIV_W-1:0]  div_count,
    input  logic [CAP_CH-1:0] chan_en,
    input  logic [CAP_CH-1:0] trig_value,
    input  logic [CAP_CH-1:0] trig_edge,
    input  logic [CAP_CH-1:0] trig_care,
    input  logic [ADDR_W-1:0] fill_limit,
    input  logic [CAP_CH-1:0] din,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CAP_CH-1:0] mem_data,
    output logic [ADDR_W-1:0] fill_level,
    output logic              stat_triggered,
    output logic              stat_mem_avail,
    output logic              stat_capturing,
    output logic [DUR_W-1:0]  duration
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(FIRST_ADDR);

    cap_flags_t        flags;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] wr_next;
    logic              restart;
    logic              tick;
    logic              hit;
    trig_cfg_t         cfg;

    assign restart = start & ~stop;
    assign wr_next = wr_ptr + 1'b1;
    assign cfg     = '{value: trig_value, edge_sel: trig_edge, care: trig_care};

    cap_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk(clk), .rst(rst), .restart(restart), .run(flags.capturing),
        .bypass(bypass), .div_count(div_count), .tick(tick)
    );

    cap_trig_unit u_trig (
        .clk(clk), .rst(rst), .restart(restart), .tick(tick),
        .cfg(cfg), .din(din), .hit(hit)
    );

    cap_dur_timer #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .DUR_W(DUR_W)) u_dur (
        .clk(clk), .rst(rst), .restart(restart), .run(flags.capturing),
        .duration(duration)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '{triggered: 1'b0, mem_avail: 1'b1, capturing: 1'b0};
            wr_ptr   <= BASE;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= 1'b0;
            if (stop) begin
                flags.capturing <= 1'b0;
            end else if (start) begin
                flags  <= '{triggered: 1'b0, mem_avail: 1'b1, capturing: 1'b1};
                wr_ptr <= BASE;
            end else if (flags.capturing && tick && (flags.triggered || hit)) begin
                flags.triggered <= 1'b1;
                mem_we          <= 1'b1;
                mem_addr        <= wr_ptr;
                mem_data        <= din & chan_en;
                wr_ptr          <= wr_next;
                if (wr_next == fill_limit) begin
                    flags.capturing <= 1'b0;
                    flags.mem_avail <= 1'b0;
                end
            end
        end
    end

    assign fill_level     = wr_ptr;
    assign stat_triggered = flags.triggered;
    assign stat_mem_avail = flags.mem_avail;
    assign stat_capturing = flags.capturing;
endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk
    import cap_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DUR_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              stop,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] fill_level,
    input logic              stat_triggered,
    input logic              stat_mem_avail,
    input logic              stat_capturing,
    input logic [DUR_W-1:0]  duration
);
    // R9
    stop_halt_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !stat_capturing);

    // R9
    stop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !mem_we);

    // R7
    write_after_trig_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> stat_triggered);

    // R7
    write_base_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr >= ADDR_W'(FIRST_ADDR)));

    // R11
    fill_tracks_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (fill_level == ADDR_W'(mem_addr + 1'b1)));

    // R11
    fill_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (fill_level >= $past(fill_level)));

    // R8
    full_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_mem_avail |-> !stat_capturing);

    // R10
    dur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_capturing && !start) |=> $stable(duration));
endmodule

bind trig_capture_ctrl cap_ctrl_chk #(.ADDR_W(ADDR_W), .DUR_W(DUR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .mem_we(mem_we),
    .mem_addr(mem_addr), .fill_level(fill_level), .stat_triggered(stat_triggered),
    .stat_mem_avail(stat_mem_avail), .stat_capturing(stat_capturing),
    .duration(duration)
);

// File: tb/trig_capture_ctrl_test.sv
module trig_capture_ctrl_test;
    localparam int MEM_DEPTH = 64;
    localparam int DIV_W     = 8;
    localparam int TICKS     = 10;
    localparam int DUR_W     = 32;
    localparam int ADDR_W    = $clog2(MEM_DEPTH);
    localparam int NV        = 9;

    // Trigger table: care, edge-select, match value, first sample, second sample,
    // expected triggered flag and fill level after the two samples and a stop.
    localparam logic [33:0] T_CARE [NV] = '{34'h0, 34'h3_0000_0000, 34'h0FF, 34'h0FF,
                                            34'h1, 34'h1, 34'h21, 34'h21, 34'h1};
    localparam logic [33:0] T_EDGE [NV] = '{34'h0, 34'h0, 34'h0, 34'h0,
                                            34'h1, 34'h1, 34'h1, 34'h1, 34'h1};
    localparam logic [33:0] T_VAL  [NV] = '{34'h0, 34'h2_0000_0000, 34'h0A5, 34'h0A5,
                                            34'h1, 34'h1, 34'h21, 34'h21, 34'h0};
    localparam logic [33:0] T_A    [NV] = '{34'h0, 34'h0, 34'h0A5, 34'h0A4,
                                            34'h0, 34'h1, 34'h20, 34'h00, 34'h1};
    localparam logic [33:0] T_B    [NV] = '{34'h0, 34'h2_0000_0000, 34'h000, 34'h1A4,
                                            34'h1, 34'h1, 34'h21, 34'h01, 34'h0};
    localparam int          T_TRIG [NV] = '{1, 1, 1, 0, 1, 0, 1, 0, 1};
    localparam int          T_FILL [NV] = '{6, 5, 6, 4, 5, 4, 5, 4, 5};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic              bypass = 1'b1;
    logic [DIV_W-1:0]  div_count = '0;
    logic [33:0]       chan_en = '1;
    logic [33:0]       trig_value = '0;
    logic [33:0]       trig_edge = '0;
    logic [33:0]       trig_care = '0;
    logic [ADDR_W-1:0] fill_limit = ADDR_W'(MEM_DEPTH - 16);
    logic [33:0]       din = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [33:0]       mem_data;
    logic [ADDR_W-1:0] fill_level;
    logic              stat_triggered;
    logic              stat_mem_avail;
    logic              stat_capturing;
    logic [DUR_W-1:0]  duration;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_capture_ctrl #(.MEM_DEPTH(MEM_DEPTH), .DIV_W(DIV_W),
                        .TICKS_PER_UNIT(TICKS), .DUR_W(DUR_W)) uut (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .bypass(bypass),
        .div_count(div_count), .chan_en(chan_en), .trig_value(trig_value),
        .trig_edge(trig_edge), .trig_care(trig_care), .fill_limit(fill_limit),
        .din(din), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .fill_level(fill_level), .stat_triggered(stat_triggered),
        .stat_mem_avail(stat_mem_avail), .stat_capturing(stat_capturing),
        .duration(duration)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        step();
        stop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int wcount;
        int first_idx;
        logic [ADDR_W-1:0] last_addr;

        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1", "capturing", stat_capturing, 0);
        chk("R1", "triggered", stat_triggered, 0);
        chk("R1", "mem_avail", stat_mem_avail, 1);
        chk("R1", "fill", fill_level, 4);
        chk("R1", "duration", duration, 0);
        chk("R1", "we", mem_we, 0);

        // Table walk: R5 level/care, R6 edges, R9 stop freezes
        for (int i = 0; i < NV; i++) begin
            trig_care  = T_CARE[i];
            trig_edge  = T_EDGE[i];
            trig_value = T_VAL[i];
            do_start();
            din = T_A[i];
            step();
            din = T_B[i];
            step();
            do_stop();
            chk((T_EDGE[i] != 0) ? "R6" : "R5", $sformatf("vec%0d trig", i),
                stat_triggered, T_TRIG[i]);
            chk((T_EDGE[i] != 0) ? "R6" : "R5", $sformatf("vec%0d fill", i),
                fill_level, T_FILL[i]);
            chk("R9", $sformatf("vec%0d capturing", i), stat_capturing, 0);
        end

        // R7 write address, data masking and timing
        trig_care = '0; trig_edge = '0; trig_value = '0;
        chan_en = 34'h0_0000_00FF;
        do_start();
        din = 34'h3_FFFF_FF12;
        step();
        chk("R7", "we first", mem_we, 1);
        chk("R7", "addr first", mem_addr, 4);
        chk("R7", "data masked", mem_data, 34'h12);
        chk("R11", "fill after first", fill_level, 5);
        din = 34'h0_0000_0134;
        step();
        chk("R7", "addr second", mem_addr, 5);
        chk("R7", "data second", mem_data, 34'h34);
        do_stop();
        chk("R9", "we after stop", mem_we, 0);
        chk("R9", "fill after stop", fill_level, 6);
        repeat (3) step();
        chk("R9", "fill frozen", fill_level, 6);
        chk("R9", "trig kept", stat_triggered, 1);
        chan_en = '1;

        // R3 divided sampling, terminal count 2
        bypass = 1'b0; div_count = 8'd2;
        do_start();
        wcount = 0; first_idx = 0;
        for (int k = 1; k <= 12; k++) begin
            step();
            if (mem_we) begin
                wcount++;
                if (first_idx == 0) first_idx = k;
            end
        end
        chk("R3", "samples in 12 edges", wcount, 4);
        chk("R3", "first sample edge", first_idx, 3);
        do_stop();

        // R4 bypass ignores terminal count
        bypass = 1'b1; div_count = 8'd5;
        do_start();
        wcount = 0;
        for (int k = 0; k < 6; k++) begin
            step();
            if (mem_we) wcount++;
        end
        chk("R4", "bypass samples", wcount, 6);
        do_stop();

        // R8 fill threshold at depth-16
        do_start();
        wcount = 0; last_addr = '0;
        for (int k = 0; k < 60; k++) begin
            step();
            if (mem_we) begin
                wcount++;
                last_addr = mem_addr;
            end
        end
        chk("R8", "writes to threshold", wcount, 44);
        chk("R8", "last addr", last_addr, 47);
        chk("R8", "fill", fill_level, 48);
        chk("R8", "mem_avail", stat_mem_avail, 0);
        chk("R8", "capturing", stat_capturing, 0);

        // R2 restart clears run state; trigger never met afterwards
        trig_care = '1; trig_value = '0; din = 34'h1;
        bypass = 1'b0; div_count = 8'd7;
        do_start();
        chk("R2", "mem_avail", stat_mem_avail, 1);
        chk("R2", "triggered", stat_triggered, 0);
        chk("R2", "fill", fill_level, 4);
        chk("R2", "capturing", stat_capturing, 1);
        chk("R2", "duration", duration, 0);

        // R10 duration in divided mode
        repeat (9) step();
        chk("R10", "dur before unit", duration, 0);
        step();
        chk("R10", "dur one unit", duration, 1);
        repeat (20) step();
        chk("R10", "dur three units", duration, 3);
        do_stop();
        repeat (15) step();
        chk("R10", "dur frozen", duration, 3);

        // R10 same count with bypass
        bypass = 1'b1;
        do_start();
        repeat (10) step();
        chk("R10", "bypass dur one unit", duration, 1);

        // R2 stop wins over simultaneous start
        start = 1'b1; stop = 1'b1;
        step();
        start = 1'b0; stop = 1'b0;
        chk("R2", "stop beats start", stat_capturing, 0);
        chk("R2", "dur kept", duration, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule